// File: doc/BRIEF.md
# Clock-Synchronous Serial Port

This block is a byte-wide, double-buffered serial port for a microcontroller, clocked entirely from the system clock. The CPU sees four registers through a small address field: a data register (writes go to the transmit buffer and reads come from the receive buffer), a status register, a control register and the reload value of a built-in baud-rate divider. A write to the data register both queues a byte and arms the next frame. When the port owns the shift clock, it generates that clock from the divider. When an external device owns it, the port follows edges on the clock input after synchronising them. Transmitter and receiver always share one shift clock.

Frames are 8 bits, least significant bit first. Output data changes on the falling edge of the shift clock and input data is taken on the rising edge. A completed frame moves into the receive buffer, or raises an overrun flag if the previous byte was never read. A byte waiting in the transmit buffer when a frame ends starts the next frame with no gap. Two single-cycle interrupt pulses come out. The receive pulse marks a newly filled receive buffer. The transmit pulse marks either an emptied transmit buffer or a finished shift, as chosen by a control bit. The bidirectional clock pin is split into an input, an output and an output enable for the pad.

Top module: `sync_serial_port`

## Requirements
- R1: After reset the status register reads 0x05 (transmit buffer empty = bit 0 set, shift complete = bit 2 set, receive full = bit 1 clear, overrun = bit 3 clear), txd and sclk_out are high, and neither interrupt pulses.
- R2: A write to address 0 while the shifter is idle moves the byte into the shifter on the next clock edge: the empty flag (status bit 0) returns to 1 and the shift-complete flag (status bit 2) drops to 0 while the frame runs.
- R3: With internal clock (control bit 0 = 0) the shift clock toggles every P = (n+1)·m system cycles, where n is the reload value at address 3 and m is 1, or 4 when control bit 1 = 1. The shift-complete flag is set 1 + 16·P cycles after the clock edge that accepts the data write. Between frames sclk_out rests high.
- R4: Bits leave on txd least significant first, each one changing only on a falling shift-clock edge. rxd is sampled on rising edges, so a port looped from txd to rxd receives the byte it sent.
- R5: At the end of a frame the received byte is loaded into the receive buffer and status bit 1 is set. A read of address 0 returns that byte and clears bit 1.
- R6: If status bit 1 is still set when a frame ends, status bit 3 (overrun) is set and the receive buffer keeps its old byte. Any write to address 1 clears bit 3.
- R7: A byte written while a frame is in flight follows the current frame back to back. The shift-complete flag stays 0 until the last queued frame ends.
- R8: With control bit 2 = 0, tx_irq pulses for one cycle when the empty flag rises. With control bit 2 = 1, it pulses when the shift-complete flag rises.
- R9: rx_irq pulses for one cycle each time status bit 1 rises.
- R10: With control bit 0 = 1, sclk_oe is 0 and the frame advances on edges of sclk_in, seen through a two-stage synchroniser.
- R11: Address 2 reads back control bits [2:0] and address 3 reads back the reload value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (read side effects only) |
| addr | input | 2 | Register select: 0 data, 1 status, 2 control, 3 reload |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register |
| sclk_in | input | 1 | Shift clock from the pad |
| sclk_out | output | 1 | Shift clock driven to the pad |
| sclk_oe | output | 1 | Pad output enable for the shift clock |
| rxd | input | 1 | Serial data input |
| txd | output | 1 | Serial data output |
| tx_irq | output | 1 | Transmit interrupt pulse |
| rx_irq | output | 1 | Receive interrupt pulse |

## Verification
The assertions assume that control and reload registers are written only while no frame is running. They also assume that an external shift clock holds each level for more than three system cycles, so no edge is lost in the synchroniser. The bench changes control and reload only between frames, after the shift-complete flag is seen. In external mode it holds each shift-clock level for five cycles and changes rxd only right after a falling edge.

// File: rtl/ssio_pkg.sv
package ssio_pkg;

   typedef enum logic [1:0] {
      REG_DATA   = 2'd0,
      REG_STATUS = 2'd1,
      REG_CTRL   = 2'd2,
      REG_RELOAD = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic irq_on_done;
      logic slow_src;
      logic ext_clk;
   } ctrl_t;

   localparam int ST_EMPTY = 0;
   localparam int ST_FULL  = 1;
   localparam int ST_DONE  = 2;
   localparam int ST_OVR   = 3;

endpackage

// File: rtl/ssio_baud_gen.sv
module ssio_baud_gen #(
   parameter int DIV_W   = 8,
   parameter int PRE_DIV = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic             slow_src,
   input  logic [DIV_W-1:0] reload,
   output logic             tick
);

   logic             src_en;
   logic [DIV_W-1:0] cnt_q;

   generate
      if (PRE_DIV > 1) begin : g_pre
         localparam int PRE_W = $clog2(PRE_DIV);
         localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);
         logic [PRE_W-1:0] pre_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       pre_q <= '0;
            else if (restart) pre_q <= '0;
            else if (run)     pre_q <= (pre_q == PRE_LAST) ? '0 : pre_q + 1'b1;
         end

         assign src_en = run & (~slow_src | (pre_q == PRE_LAST));
      end else begin : g_nopre
         logic unused_sel;
         assign unused_sel = slow_src;
         assign src_en     = run;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (restart) cnt_q <= reload;
      else if (src_en)  cnt_q <= (cnt_q == '0) ? reload : cnt_q - 1'b1;
   end

   assign tick = src_en & (cnt_q == '0);

   p_count_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!restart && !run) |=> $stable(cnt_q));

endmodule

// File: rtl/ssio_clk_ctl.sv
module ssio_clk_ctl #(
   parameter int DIV_W       = 8,
   parameter int PRE_DIV     = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ext_sel,
   input  logic             slow_src,
   input  logic [DIV_W-1:0] reload,
   input  logic             busy,
   input  logic             restart,
   input  logic             sclk_in,
   input  logic             rxd,
   output logic             fall_ev,
   output logic             rise_ev,
   output logic             rx_bit,
   output logic             sclk_out
);

   logic                   tick;
   logic                   sclk_q;
   logic [SYNC_STAGES:0]   s_pipe;
   logic [SYNC_STAGES-1:0] r_pipe;
   logic                   ext_fall, ext_rise;

   ssio_baud_gen #(.DIV_W(DIV_W), .PRE_DIV(PRE_DIV)) u_baud (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (busy & ~ext_sel),
      .restart  (restart),
      .slow_src (slow_src),
      .reload   (reload),
      .tick     (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       sclk_q <= 1'b1;
      else if (restart)                 sclk_q <= 1'b1;
      else if (busy && !ext_sel && tick) sclk_q <= ~sclk_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_pipe <= '1;
         r_pipe <= '0;
      end else begin
         s_pipe <= {s_pipe[SYNC_STAGES-1:0], sclk_in};
         r_pipe <= {r_pipe[SYNC_STAGES-2:0], rxd};
      end
   end

   assign ext_fall = s_pipe[SYNC_STAGES] & ~s_pipe[SYNC_STAGES-1];
   assign ext_rise = ~s_pipe[SYNC_STAGES] & s_pipe[SYNC_STAGES-1];

   assign fall_ev  = busy & (ext_sel ? ext_fall : (tick & sclk_q));
   assign rise_ev  = busy & (ext_sel ? ext_rise : (tick & ~sclk_q));
   assign rx_bit   = ext_sel ? r_pipe[SYNC_STAGES-1] : rxd;
   assign sclk_out = sclk_q;

   p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !ext_sel) |-> sclk_q);

   p_ext_clk_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_sel && !restart) |=> $stable(sclk_q));

endmodule

// File: rtl/ssio_shifter.sv
module ssio_shifter #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_data,
   input  logic              fall_ev,
   input  logic              rise_ev,
   input  logic              rx_bit,
   output logic              txd,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rx_word
);

   localparam int CNT_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

   logic [CNT_W-1:0]  cnt_q;
   logic [DATA_W-1:0] tx_sh, rx_sh;
   logic              txd_q, busy_q;

   assign done    = busy_q & rise_ev & (cnt_q == LAST_BIT);
   assign rx_word = {rx_bit, rx_sh[DATA_W-1:1]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
         tx_sh  <= '0;
         rx_sh  <= '0;
         txd_q  <= 1'b1;
      end else begin
         if (fall_ev) begin
            txd_q <= tx_sh[0];
            tx_sh <= tx_sh >> 1;
         end
         if (rise_ev) begin
            rx_sh <= rx_word;
            cnt_q <= cnt_q + 1'b1;
         end
         if (load) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            tx_sh  <= load_data;
         end else if (done) begin
            busy_q <= 1'b0;
         end
      end
   end

   assign txd  = txd_q;
   assign busy = busy_q;

   p_txd_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !fall_ev |=> $stable(txd_q));

   p_no_event_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> !(fall_ev || rise_ev) || load);

endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port #(
   parameter int DATA_W      = 8,
   parameter int DIV_W       = 8,
   parameter int PRE_DIV     = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              sclk_in,
   output logic              sclk_out,
   output logic              sclk_oe,
   input  logic              rxd,
   output logic              txd,
   output logic              tx_irq,
   output logic              rx_irq
);
   import ssio_pkg::*;

   localparam int CTRL_W = $bits(ctrl_t);

   generate
      if (DATA_W < 4)           begin : g_bad_data  $error("DATA_W must be at least 4"); end
      if (DIV_W > DATA_W)       begin : g_bad_div   $error("DIV_W must not exceed DATA_W"); end
      if (PRE_DIV < 1)          begin : g_bad_pre   $error("PRE_DIV must be at least 1"); end
      if (SYNC_STAGES < 2)      begin : g_bad_sync  $error("SYNC_STAGES must be at least 2"); end
   endgenerate

   reg_sel_e          sel;
   ctrl_t             ctrl_q;
   logic [DIV_W-1:0]  reload_q;
   logic [DATA_W-1:0] tx_buf, rx_buf, rx_word;
   logic              tbe, tsc, rbf, oe;
   logic              tbe_q, tsc_q, rbf_q;
   logic              busy, done, load, fall_ev, rise_ev, rx_bit;
   logic              data_wr, data_rd, stat_wr, rbf_kept;

   assign sel      = reg_sel_e'(addr);
   assign data_wr  = wr_en & (sel == REG_DATA);
   assign data_rd  = rd_en & (sel == REG_DATA);
   assign stat_wr  = wr_en & (sel == REG_STATUS);
   assign rbf_kept = rbf & ~data_rd;
   assign load     = ~tbe & (~busy | done);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         reload_q <= '0;
      end else if (wr_en) begin
         if (sel == REG_CTRL)   ctrl_q   <= ctrl_t'(wdata[CTRL_W-1:0]);
         if (sel == REG_RELOAD) reload_q <= wdata[DIV_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_buf <= '0;
         tbe    <= 1'b1;
         tsc    <= 1'b1;
      end else begin
         if (load)         tbe <= 1'b1;
         if (data_wr) begin
            tx_buf <= wdata;
            tbe    <= 1'b0;
         end
         if (load)         tsc <= 1'b0;
         else if (done)    tsc <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_buf <= '0;
         rbf    <= 1'b0;
         oe     <= 1'b0;
      end else begin
         rbf <= done | rbf_kept;
         if (stat_wr) oe <= 1'b0;
         if (done) begin
            if (rbf_kept) oe     <= 1'b1;
            else          rx_buf <= rx_word;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tbe_q <= 1'b1;
         tsc_q <= 1'b1;
         rbf_q <= 1'b0;
      end else begin
         tbe_q <= tbe;
         tsc_q <= tsc;
         rbf_q <= rbf;
      end
   end

   assign tx_irq = ctrl_q.irq_on_done ? (tsc & ~tsc_q) : (tbe & ~tbe_q);
   assign rx_irq = rbf & ~rbf_q;

   always_comb begin
      unique case (sel)
         REG_DATA:   rdata = rx_buf;
         REG_STATUS: rdata = DATA_W'({oe, tsc, rbf, tbe});
         REG_CTRL:   rdata = DATA_W'(ctrl_q);
         default:    rdata = DATA_W'(reload_q);
      endcase
   end

   ssio_clk_ctl #(.DIV_W(DIV_W), .PRE_DIV(PRE_DIV), .SYNC_STAGES(SYNC_STAGES)) u_clk (
      .clk      (clk),
      .rst_n    (rst_n),
      .ext_sel  (ctrl_q.ext_clk),
      .slow_src (ctrl_q.slow_src),
      .reload   (reload_q),
      .busy     (busy),
      .restart  (load),
      .sclk_in  (sclk_in),
      .rxd      (rxd),
      .fall_ev  (fall_ev),
      .rise_ev  (rise_ev),
      .rx_bit   (rx_bit),
      .sclk_out (sclk_out)
   );

   ssio_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_data (tx_buf),
      .fall_ev   (fall_ev),
      .rise_ev   (rise_ev),
      .rx_bit    (rx_bit),
      .txd       (txd),
      .busy      (busy),
      .done      (done),
      .rx_word   (rx_word)
   );

   assign sclk_oe = ~ctrl_q.ext_clk;

   p_done_flag_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !tsc);

   p_full_from_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rbf) |-> $past(done));

   p_overrun_needs_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe) |-> $past(rbf));

   p_overrun_keeps_buf_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe) |-> $stable(rx_buf));

   p_rx_pulse_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rx_irq |=> !rx_irq);

endmodule

// File: tb/sync_serial_port_bench.sv
module sync_serial_port_bench;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0, rd_en = 1'b0;
   logic [1:0] addr = 2'd1;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       sclk_in = 1'b1, sclk_out, sclk_oe;
   logic       rxd, txd, tx_irq, rx_irq;
   logic       loop_en = 1'b1, rxd_drv = 1'b0;

   int checks = 0, errors = 0;
   int ntx = 0, nrx = 0;
   int ntx_at3;
   logic [7:0] stat_at3;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;
   assign rxd = loop_en ? txd : rxd_drv;

   sync_serial_port u_sync_serial_port (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .sclk_in(sclk_in), .sclk_out(sclk_out),
      .sclk_oe(sclk_oe), .rxd(rxd), .txd(txd), .tx_irq(tx_irq), .rx_irq(rx_irq)
   );

   always @(posedge clk) if (rst_n) begin
      if (tx_irq) ntx++;
      if (rx_irq) nrx++;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr_en = 1'b0; addr = 2'd1;
   endtask

   task automatic reg_read(input logic [1:0] a, output logic [7:0] v);
      @(negedge clk); addr = a; rd_en = (a == 2'd0); #1 v = rdata;
      @(negedge clk); rd_en = 1'b0; addr = 2'd1;
   endtask

   // counts posedges after the accepting edge until status bit 2 is seen
   task automatic measure(input int inject_at, input logic [7:0] inject_val, output int cyc);
      cyc = 0;
      forever begin
         @(posedge clk); cyc++;
         @(negedge clk);
         if (cyc == inject_at) begin
            wr_en = 1'b1; addr = 2'd0; wdata = inject_val;
         end else begin
            wr_en = 1'b0; addr = 2'd1; #1;
            if (cyc == 3) begin ntx_at3 = ntx; stat_at3 = rdata; end
            if (rdata[2] || cyc > 5000) break;
         end
      end
      wr_en = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      logic [7:0] v;
      int cyc, p, ntx0, nrx0;
      int nlist[4] = '{0, 1, 3, 6};

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      check("R1 status", rdata, 8'h05);
      check("R1 txd", txd, 1'b1);
      check("R1 sclk_out", sclk_out, 1'b1);
      check("R1 irqs", {tx_irq, rx_irq}, 2'b00);

      // R11 register map
      reg_write(2'd2, 8'h06); reg_read(2'd2, v); check("R11 ctrl", v, 8'h06);
      reg_write(2'd3, 8'h5A); reg_read(2'd3, v); check("R11 reload", v, 8'h5A);

      // Sweep of divider settings with loopback
      for (int d = 0; d < 2; d++) begin
         for (int k = 0; k < 4; k++) begin
            logic [7:0] pat;
            int n;
            n = nlist[k];
            pat = 8'(8'h35 + n * 29 + d * 100);
            p = (n + 1) * (d ? 4 : 1);
            reg_write(2'd3, 8'(n));
            reg_write(2'd2, 8'({n[0], d[0], 1'b0}));
            repeat (2) @(negedge clk);
            ntx0 = ntx; nrx0 = nrx;
            reg_write(2'd0, pat);
            measure(-1, 8'h00, cyc);
            check("R2 flags mid-frame", stat_at3[2:0], 3'b001);
            check("R8 tx irq at load", ntx_at3, ntx0 + (n[0] ? 0 : 1));
            check("R3 frame length", cyc, 1 + 16 * p);
            check("R3 sclk idle", sclk_out, 1'b1);
            repeat (2) @(negedge clk);
            check("R8 tx irq total", ntx, ntx0 + 1);
            check("R9 rx irq", nrx, nrx0 + 1);
            #1 check("R5 full flag", rdata[1], 1'b1);
            reg_read(2'd0, v);
            check("R4 loopback byte", v, pat);
            #1 check("R5 read clears full", rdata[1], 1'b0);
         end
      end

      // Back to back frames, second overruns the unread first
      reg_write(2'd3, 8'd2);
      reg_write(2'd2, 8'h00);
      reg_write(2'd0, 8'hC3);
      measure(4, 8'h5E, cyc);
      check("R7 back-to-back length", cyc, 1 + 32 * 3);
      #1 check("R6 overrun flag", rdata[3], 1'b1);
      reg_write(2'd1, 8'h00);
      #1 check("R6 overrun cleared", rdata[3], 1'b0);
      reg_read(2'd0, v);
      check("R6 buffer kept", v, 8'hC3);

      // External clock mode
      begin
         logic [7:0] xmit, recv, seen;
         xmit = 8'h96; recv = 8'h4B; seen = '0;
         loop_en = 1'b0;
         reg_write(2'd2, 8'h01);
         #1 check("R10 sclk_oe off", sclk_oe, 1'b0);
         reg_write(2'd0, xmit);
         repeat (3) @(negedge clk);
         for (int i = 0; i < 8; i++) begin
            sclk_in = 1'b0; rxd_drv = recv[i];
            repeat (5) @(negedge clk);
            seen[i] = txd;
            sclk_in = 1'b1;
            repeat (5) @(negedge clk);
         end
         repeat (3) @(negedge clk);
         check("R10 ext txd byte", seen, xmit);
         #1 check("R10 ext flags", rdata[2:1], 2'b11);
         reg_read(2'd0, v);
         check("R10 ext rx byte", v, recv);
      end

      report();
   end

endmodule